// File: doc/BRIEF.md
# Parity-Inserting Asynchronous Serial Transmitter

This block is the transmit half of an asynchronous serial port. It runs from a single serial clock. An internal 4-bit divider produces one bit tick every 16 clocks. When the host strobes a byte in, the block takes a snapshot of the byte and of the frame settings. It waits for the next bit tick and then drives a frame onto the line. The frame is a low start bit, the data least significant bit first, an optional extra slot, and a high stop bit.

Three frame formats are supported, and the extra slot is filled differently in each. In the 7-bit format the generated parity takes the place of data bit 7. In the 8-bit format the parity is sent as a separate ninth slot. In the 9-bit format the ninth slot carries a bit supplied by the host, and the parity settings are ignored. Busy is high from the accepted write until the stop bit has lasted its full bit time. At that point a single-cycle interrupt reports that the buffer is empty.

Top module: `serial_tx_framer`

## Requirements
- R1: A bit tick occurs on every 16th serial clock. The first tick after reset is the 16th rising edge with reset low. The line changes only on tick edges, so each bit lasts 16 clocks.
- R2: An accepted write drives the line low (start bit) on the first tick edge after the write edge.
- R3: The line is high while idle. Every frame ends with one high stop bit lasting a full bit time.
- R4: Data bits are sent least significant bit first, one per bit time.
- R5: Format code 2'b00 (7-bit): `wr_data[6:0]` is sent, and then the bit-7 slot. With parity off that slot carries `wr_data[7]`; with parity on it carries the parity of `wr_data[6:0]`. The stop bit follows.
- R6: Format codes 2'b01 and 2'b11 (8-bit): `wr_data[7:0]` is sent. With parity on, a ninth slot carrying the parity of all 8 bits follows, then the stop bit. With parity off, the stop bit follows the data directly.
- R7: Format code 2'b10 (9-bit): `wr_data[7:0]` is sent, then `ninth_bit`, then the stop bit. `par_en` and `par_even` have no effect.
- R8: With `par_even`=1 the parity bit makes the count of ones over the covered data plus parity even. With `par_even`=0 it makes that count odd.
- R9: Data, format, parity settings and ninth bit are captured on the accepted write. Changing those inputs afterwards does not alter the frame.
- R10: A write while busy is ignored. It neither alters the current frame nor starts another one afterwards.
- R11: `busy` rises on the edge that accepts a write. It falls one bit time after the stop bit began. `tx_empty_irq` is high for exactly the one cycle after `busy` falls.
- R12: After reset: `tx`=1, `busy`=0, `tx_empty_irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock (16 clocks per bit) |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe for the transmit buffer |
| wr_data | input | 8 | Host byte to send |
| mode | input | 2 | Frame format: 00 7-bit, 01/11 8-bit, 10 9-bit |
| par_en | input | 1 | Parity generation enable (7/8-bit formats) |
| par_even | input | 1 | 1 even parity, 0 odd parity |
| ninth_bit | input | 1 | Host-supplied ninth bit for the 9-bit format |
| tx | output | 1 | Serial line, idle high |
| busy | output | 1 | Frame pending or in progress |
| tx_empty_irq | output | 1 | One-cycle pulse when the buffer has shifted out |

## Verification
Frames are sent with all-zero, all-one and top-bit-only bytes in every format, with parity on and off in both senses. This separates a parity that replaces bit 7 from one appended as a ninth slot, and shows whether parity wrongly leaks into the 9-bit format. Random bytes and settings then cover all four format codes. Right after each write the settings inputs are scrambled, which separates snapshotting from live use. On some frames a second write is injected mid-frame, and the line is then watched for an unwanted second frame. The start edge is checked against the tick grid, and busy and the interrupt are sampled on both sides of the final tick edge.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_W  = 8;
    localparam int FRAME_W = DATA_W + 2;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        FMT_7  = 2'b00,
        FMT_8  = 2'b01,
        FMT_9  = 2'b10,
        FMT_8B = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ARMED = 2'b01,
        ST_SHIFT = 2'b10
    } st_e;

    // bits[0] leaves first after the start bit; the slot at len-1 is the stop bit
    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [LEN_W-1:0]   len;
    } frame_t;

    function automatic logic parity_of(input logic [DATA_W-1:0] d,
                                       input logic [DATA_W-1:0] mask,
                                       input logic even);
        return even ? ^(d & mask) : ~^(d & mask);
    endfunction

    function automatic frame_t build_frame(input logic [DATA_W-1:0] d,
                                           input fmt_e fmt,
                                           input logic pe,
                                           input logic ev,
                                           input logic nb);
        frame_t f;
        f.bits = '1;
        f.len  = LEN_W'(DATA_W + 1);
        f.bits[DATA_W-1:0] = d;
        case (fmt)
            FMT_7: begin
                if (pe)
                    f.bits[DATA_W-1] = parity_of(d, {1'b0, {(DATA_W-1){1'b1}}}, ev);
            end
            FMT_9: begin
                f.bits[DATA_W] = nb;
                f.len          = LEN_W'(DATA_W + 2);
            end
            default: begin
                if (pe) begin
                    f.bits[DATA_W] = parity_of(d, {DATA_W{1'b1}}, ev);
                    f.len          = LEN_W'(DATA_W + 2);
                end
            end
        endcase
        return f;
    endfunction

endpackage

// File: rtl/sertx_tick_div.sv
module sertx_tick_div #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (cnt == LAST)  cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    generate
        if (DIV > 1) begin : g_gap_chk
            assert_tick_gap_R1: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/sertx_frame_build.sv
module sertx_frame_build
    import sertx_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        mode,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              ninth_bit,
    output frame_t            frame
);
    always_comb begin
        frame = build_frame(data, fmt_e'(mode), par_en, par_even, ninth_bit);
    end
endmodule

// File: rtl/sertx_shift_engine.sv
module sertx_shift_engine
    import sertx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   load,
    input  frame_t frame_in,
    output logic   tx,
    output logic   busy,
    output logic   irq
);
    st_e                st;
    logic [FRAME_W-1:0] shreg;
    logic [LEN_W-1:0]   rem;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            shreg <= '1;
            rem   <= '0;
            tx    <= 1'b1;
            irq   <= 1'b0;
        end else begin
            irq <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (load) begin
                        shreg <= frame_in.bits;
                        rem   <= frame_in.len;
                        st    <= ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (tick) begin
                        tx <= 1'b0;
                        st <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (rem != '0) begin
                            tx    <= shreg[0];
                            shreg <= {1'b1, shreg[FRAME_W-1:1]};
                            rem   <= rem - 1'b1;
                        end else begin
                            tx  <= 1'b1;
                            st  <= ST_IDLE;
                            irq <= 1'b1;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy = (st != ST_IDLE);

    assert_idle_line_high_R3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx);
    assert_edge_on_tick_R1: assert property (@(posedge clk) disable iff (rst)
        !$stable(tx) |-> $past(tick));
    assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ARMED && tick) |=> (!tx && busy));
    assert_ignore_busy_write_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && load && !tick) |=> $stable(shreg));
    assert_irq_single_R11: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
    assert_irq_after_busy_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> (!busy && $past(busy)));

endmodule

// File: rtl/serial_tx_framer.sv
module serial_tx_framer
    import sertx_pkg::*;
#(
    parameter int DIV = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        mode,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              ninth_bit,
    output logic              tx,
    output logic              busy,
    output logic              tx_empty_irq
);
    logic   tick;
    frame_t frame;

    sertx_tick_div #(.DIV(DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    sertx_frame_build u_build (
        .data      (wr_data),
        .mode      (mode),
        .par_en    (par_en),
        .par_even  (par_even),
        .ninth_bit (ninth_bit),
        .frame     (frame)
    );

    sertx_shift_engine u_eng (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (wr_en),
        .frame_in (frame),
        .tx       (tx),
        .busy     (busy),
        .irq      (tx_empty_irq)
    );

    assert_busy_on_write_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy) |=> busy);

endmodule

// File: tb/tb_serial_tx_framer.sv
module tb_serial_tx_framer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] mode = 2'b00;
    logic       par_en = 1'b0;
    logic       par_even = 1'b0;
    logic       ninth_bit = 1'b0;
    logic       tx, busy, tx_empty_irq;

    int checks = 0;
    int errors = 0;
    int ncyc   = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst) ncyc <= 0;
        else     ncyc <= ncyc + 1;
    end

    serial_tx_framer dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .mode(mode),
        .par_en(par_en), .par_even(par_even), .ninth_bit(ninth_bit),
        .tx(tx), .busy(busy), .tx_empty_irq(tx_empty_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic bit par(input logic [7:0] d, input bit ev);
        return ev ? ^d : ~^d;
    endfunction

    // expected slots after the start bit, stop included; length via ref
    function automatic logic [9:0] exp_bits(input logic [7:0] d, input logic [1:0] m,
                                            input bit pe, input bit ev, input bit nb,
                                            output int len);
        logic [9:0] b = 10'h3FF;
        b[7:0] = d;
        len = 9;
        if (m == 2'b00) begin
            if (pe) b[7] = par({1'b0, d[6:0]}, ev);
        end else if (m == 2'b10) begin
            b[8] = nb;
            len  = 10;
        end else if (pe) begin
            b[8] = par(d, ev);
            len  = 10;
        end
        return b;
    endfunction

    function automatic string tag_for(input int j, input int len, input logic [1:0] m, input bit pe);
        if (j == len - 1) return "R3 stop";
        if (j < 7)        return "R4 data";
        if (m == 2'b00)   return pe ? "R5/R8 bit7 slot" : "R5 bit7 slot";
        if (m == 2'b10)   return "R7 ninth";
        if (j == 7)       return "R4 data";
        return "R6/R8 parity slot";
    endfunction

    task automatic run_frame(input logic [7:0] d, input logic [1:0] m, input bit pe,
                             input bit ev, input bit nb, input bit inj);
        int len;
        int w;
        int bad = 0;
        bit second = 0;
        logic [9:0] eb = exp_bits(d, m, pe, ev, nb, len);
        @(negedge clk);
        wr_en = 1; wr_data = d; mode = m; par_en = pe; par_even = ev; ninth_bit = nb;
        @(negedge clk);
        wr_en = 0;
        chk(busy === 1'b1, "R11 busy after write", busy, 1);
        // scramble settings after capture (R9)
        wr_data = ~d; mode = 2'($urandom); par_en = ~pe; par_even = ~ev; ninth_bit = ~nb;
        w = 0;
        while (tx !== 1'b0 && w < 40) begin @(negedge clk); w++; end
        chk(tx === 1'b0 && w <= 16, "R2 start within one bit time", w, 16);
        chk(ncyc % 16 == 0, "R1 start on tick grid", ncyc % 16, 0);
        repeat (8) @(negedge clk);
        chk(tx === 1'b0, "R2 start bit mid", tx, 0);
        for (int j = 0; j < len; j++) begin
            if (inj && j == 2) begin
                wr_en = 1; wr_data = 8'hA5;
                @(negedge clk);
                wr_en = 0;
                repeat (15) @(negedge clk);
            end else begin
                repeat (16) @(negedge clk);
            end
            if (tx !== eb[j]) bad++;
            chk(tx === eb[j], tag_for(j, len, m, pe), tx, eb[j]);
        end
        chk(bad == 0, "R9 frame intact after inputs changed", bad, 0);
        repeat (7) @(negedge clk);
        chk(busy === 1'b1 && tx_empty_irq === 1'b0, "R11 busy through stop bit",
            {busy, tx_empty_irq}, 2);
        @(negedge clk);
        chk(busy === 1'b0 && tx_empty_irq === 1'b1, "R11 irq when busy falls",
            {busy, tx_empty_irq}, 1);
        @(negedge clk);
        chk(tx_empty_irq === 1'b0, "R11 irq single cycle", tx_empty_irq, 0);
        if (inj) begin
            for (int k = 0; k < 40; k++) begin
                if (tx !== 1'b1 || busy !== 1'b0) second = 1;
                @(negedge clk);
            end
            chk(!second, "R10 busy write started no frame", second, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(tx === 1'b1 && busy === 1'b0 && tx_empty_irq === 1'b0, "R12 reset state",
            {tx, busy, tx_empty_irq}, 4);
        repeat (5) @(negedge clk);
        chk(tx === 1'b1, "R3 idle high", tx, 1);
        // directed corners
        run_frame(8'h00, 2'b00, 1, 0, 0, 0); // R5 odd parity replaces bit 7
        run_frame(8'h80, 2'b00, 1, 1, 0, 0); // R5 bit 7 dropped from parity
        run_frame(8'h80, 2'b00, 0, 0, 0, 1); // R5 parity off keeps bit 7, R10
        run_frame(8'hFF, 2'b01, 1, 1, 0, 0); // R6 even parity ninth slot
        run_frame(8'h01, 2'b01, 1, 0, 0, 0); // R8 odd sense
        run_frame(8'hFF, 2'b11, 0, 0, 1, 0); // R6 no ninth slot
        run_frame(8'h3C, 2'b10, 1, 1, 1, 0); // R7 parity ignored, ninth=1
        run_frame(8'hFF, 2'b10, 1, 0, 0, 1); // R7 ninth=0
        for (int i = 0; i < 20; i++) begin
            repeat (int'($urandom_range(0, 20))) @(negedge clk);
            run_frame(8'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                      1'($urandom), 1'($urandom));
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule